// File: doc/BRIEF.md
# Dual-Bank Port Capture and Interrupt Controller

This block serves two 16-bit input ports, A and B, through one shared command register location and one shared data location. A bank-select input chooses which port a host access reaches. Each port holds a three-bit command: an edge-interrupt enable, a latch-clock selector and a data-available interrupt enable. Each port also holds a capture register, a data-available flag and an edge-pending flag.

A port latches its input word on one of two sources. The first is an internal tick that divides the system clock down to 1 MHz. The second is the rising edge of the port's own capture strobe, which passes through a two-flop synchronizer. Latching a word raises the port's data-available flag. If the new word differs from the previous one, the edge-pending flag is also set. The host clears both flags by reading that port's data.

A single interrupt output combines the enabled requests of both ports under a global enable. Two hazards are handled in hardware. Data-available interrupts are ignored while the internal tick drives the latch. Switching a port from internal to external clocking clears its data-available flag and drops any capture that lands in a short blanking window.

Top module: `bank_capture_ctrl`

## Requirements
- R1: The command readback always shows ones in bits 15..3. Bits 2..0 show the last value written to the selected bank, or 0 after reset. Host writes to bits 15..3 have no effect.
- R2: With `bank_sel`=0, command writes, command reads, data reads and read-clears act on port A only. With `bank_sel`=1 they act on port B only. The other port's state is unchanged.
- R3: With command bit 1 = 0, the port latches its input on every internal tick. A tick occurs once every TICK_DIV system clocks; the first comes at the TICK_DIV-th clock edge after reset is released.
- R4: With command bit 1 = 1, a rising strobe latches the input word. The latched word and the `dav` bit appear after the third clock edge that follows the strobe going high.
- R5: A latch sets the port's `dav` bit. A data read of that bank clears `dav` one edge later. If a latch happens in the same cycle as the read, the latch wins.
- R6: A set `dav` requests an interrupt only when command bit 2 = 1, command bit 1 = 1 and `irq_glob_en` = 1.
- R7: While command bit 1 = 0, `dav` never raises `irq`, even when command bit 2 = 1.
- R8: The capture register resets to 0. A latch whose word differs from the previously latched word sets edge-pending. Edge-pending requests an interrupt when command bit 0 = 1 and the global enable is on. A data read of that bank clears edge-pending.
- R9: A command write that changes bit 1 from 0 to 1 clears that port's `dav`. It also discards captures in the write cycle and in the BLANK_CYC cycles after it.
- R10: `irq` is the OR of both ports' enabled requests, and it is 0 whenever `irq_glob_en` = 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| bank_sel | input | 1 | Selects port A (0) or port B (1) for host access |
| irq_glob_en | input | 1 | Global interrupt enable |
| cmd_wr | input | 1 | Command write strobe |
| cmd_wdata | input | 16 | Command write data; bits 2..0 are used |
| cmd_rdata | output | 16 | Command readback of the selected bank |
| data_rd | input | 1 | Data read strobe; clears flags of the selected bank |
| data_rdata | output | 16 | Capture register of the selected bank |
| in_a | input | 16 | Port A input word |
| in_b | input | 16 | Port B input word |
| strobe_a | input | 1 | Port A external capture strobe (asynchronous) |
| strobe_b | input | 1 | Port B external capture strobe (asynchronous) |
| dav | output | 2 | Data-available flags; bit 0 is port A, bit 1 is port B |
| irq | output | 1 | Interrupt request |

## Verification
Command writes appear in the readback one edge after the write. `irq` follows the flag and command registers with no further delay, so a change of the global enable shows on `irq` in the same cycle. An external strobe reaches `dav` and the capture register after three edges: two synchronizer flops and the edge detector. The bench samples one negative edge before that point to see the old value and one negative edge after it to see the new one. Internal-tick captures are checked after more than one tick period has passed. The blanking test raises a strobe so that its detected edge falls in the window after the switching write, then confirms that `dav` stays low.

// File: rtl/cap_pkg.sv
package cap_pkg;
  localparam int CMD_W = 3;

  typedef struct packed {
    logic dav_irq_en;   // bit 2
    logic ext_clk;      // bit 1
    logic edge_irq_en;  // bit 0
  } cmd_t;
endpackage

// File: rtl/cap_tick_gen.sv
module cap_tick_gen #(
  parameter int DIV = 50
) (
  input  logic clk,
  input  logic rst_n,
  output logic tick
);
  localparam int CNT_W = (DIV > 1) ? $clog2(DIV) : 1;

  logic [CNT_W-1:0] cnt_q, cnt_d;

  assign tick = (cnt_q == CNT_W'(DIV - 1));

  always_comb begin
    if (tick) cnt_d = '0;
    else      cnt_d = cnt_q + CNT_W'(1);
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) cnt_q <= '0;
    else        cnt_q <= cnt_d;
  end
endmodule

// File: rtl/cap_strobe_sync.sv
module cap_strobe_sync (
  input  logic clk,
  input  logic rst_n,
  input  logic strobe,
  output logic rise
);
  logic s1_q, s2_q, s3_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      s1_q <= 1'b0;
      s2_q <= 1'b0;
      s3_q <= 1'b0;
    end else begin
      s1_q <= strobe;
      s2_q <= s1_q;
      s3_q <= s2_q;
    end
  end

  assign rise = s2_q & ~s3_q;
endmodule

// File: rtl/cap_port_chan.sv
module cap_port_chan
  import cap_pkg::*;
#(
  parameter int DW        = 16,
  parameter int BLANK_CYC = 2
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          tick,
  input  logic          strobe_rise,
  input  logic          cmd_we,
  input  cmd_t          cmd_wdata,
  input  logic          data_rd,
  input  logic [DW-1:0] pin,
  output cmd_t          cmd_q,
  output logic [DW-1:0] word_q,
  output logic          dav_q,
  output logic          edge_q,
  output logic          blank,
  output logic          irq_req
);
  localparam int BW = $clog2(BLANK_CYC + 1);

  cmd_t          cmd_d;
  logic [BW-1:0] blank_q, blank_d;
  logic          dav_d, edge_d;
  logic          switching, cap_src, cap_ok, word_diff;

  // internal -> external transition on this write
  assign switching = cmd_we & ~cmd_q.ext_clk & cmd_wdata.ext_clk;
  assign cap_src   = cmd_q.ext_clk ? strobe_rise : tick;
  assign blank     = (blank_q != '0);
  assign cap_ok    = cap_src & ~switching & ~blank;
  assign word_diff = (pin != word_q);

  always_comb begin
    cmd_d = cmd_we ? cmd_wdata : cmd_q;

    if (switching)    dav_d = 1'b0;
    else if (cap_ok)  dav_d = 1'b1;
    else if (data_rd) dav_d = 1'b0;
    else              dav_d = dav_q;

    if (cap_ok && word_diff) edge_d = 1'b1;
    else if (data_rd)        edge_d = 1'b0;
    else                     edge_d = edge_q;

    if (switching)  blank_d = BW'(BLANK_CYC);
    else if (blank) blank_d = blank_q - BW'(1);
    else            blank_d = blank_q;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cmd_q   <= '0;
      dav_q   <= 1'b0;
      edge_q  <= 1'b0;
      blank_q <= '0;
    end else begin
      cmd_q   <= cmd_d;
      dav_q   <= dav_d;
      edge_q  <= edge_d;
      blank_q <= blank_d;
    end
  end

  // capture register with explicit clock enable
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)      word_q <= '0;
    else if (cap_ok) word_q <= pin;
  end

  // data-available requests only count in external-clock mode
  assign irq_req = (cmd_q.edge_irq_en & edge_q)
                 | (cmd_q.dav_irq_en & cmd_q.ext_clk & dav_q);
endmodule

// File: rtl/bank_capture_ctrl.sv
module bank_capture_ctrl
  import cap_pkg::*;
#(
  parameter int DW        = 16,
  parameter int REG_W     = 16,
  parameter int TICK_DIV  = 50,
  parameter int BLANK_CYC = 2
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             bank_sel,
  input  logic             irq_glob_en,
  input  logic             cmd_wr,
  input  logic [REG_W-1:0] cmd_wdata,
  output logic [REG_W-1:0] cmd_rdata,
  input  logic             data_rd,
  output logic [DW-1:0]    data_rdata,
  input  logic [DW-1:0]    in_a,
  input  logic [DW-1:0]    in_b,
  input  logic             strobe_a,
  input  logic             strobe_b,
  output logic [1:0]       dav,
  output logic             irq
);
  localparam int NPORT = 2;
  localparam int PAD_W = REG_W - CMD_W;

  logic                     tick;
  logic [NPORT-1:0]         strobes, rises, hit;
  logic [NPORT-1:0][DW-1:0] pins, words;
  cmd_t [NPORT-1:0]         cmds;
  logic [NPORT-1:0]         ext_sel_v, edge_v, blank_v, req_v, dav_v;
  cmd_t                     wr_cmd;

  assign strobes = {strobe_b, strobe_a};
  assign pins    = {in_b, in_a};
  assign wr_cmd  = cmd_t'(cmd_wdata[CMD_W-1:0]);

  cap_tick_gen #(.DIV(TICK_DIV)) u_tick (
    .clk   (clk),
    .rst_n (rst_n),
    .tick  (tick)
  );

  for (genvar i = 0; i < NPORT; i++) begin : g_port
    assign hit[i] = (bank_sel == 1'(i));

    cap_strobe_sync u_sync (
      .clk    (clk),
      .rst_n  (rst_n),
      .strobe (strobes[i]),
      .rise   (rises[i])
    );

    cap_port_chan #(.DW(DW), .BLANK_CYC(BLANK_CYC)) u_chan (
      .clk         (clk),
      .rst_n       (rst_n),
      .tick        (tick),
      .strobe_rise (rises[i]),
      .cmd_we      (cmd_wr & hit[i]),
      .cmd_wdata   (wr_cmd),
      .data_rd     (data_rd & hit[i]),
      .pin         (pins[i]),
      .cmd_q       (cmds[i]),
      .word_q      (words[i]),
      .dav_q       (dav_v[i]),
      .edge_q      (edge_v[i]),
      .blank       (blank_v[i]),
      .irq_req     (req_v[i])
    );

    assign ext_sel_v[i] = cmds[i].ext_clk;
  end

  assign cmd_rdata  = {{PAD_W{1'b1}}, cmds[bank_sel]};
  assign data_rdata = words[bank_sel];
  assign dav        = dav_v;
  assign irq        = irq_glob_en & (|req_v);
endmodule

// File: rtl/bank_capture_ctrl_chk.sv
module bank_capture_ctrl_chk #(
  parameter int DW    = 16,
  parameter int REG_W = 16
) (
  input logic             clk,
  input logic             rst_n,
  input logic             irq_glob_en,
  input logic             irq,
  input logic [REG_W-1:0] cmd_rdata,
  input logic [1:0]       dav,
  input logic [1:0]       ext_sel,
  input logic [1:0]       edge_pend,
  input logic [1:0]       blank,
  input logic [DW-1:0]    word_a,
  input logic [DW-1:0]    word_b
);
  assert_upper_ones_R1: assert property (@(posedge clk) disable iff (!rst_n)
    cmd_rdata[REG_W-1:3] == {(REG_W-3){1'b1}});

  assert_glob_gate_R10: assert property (@(posedge clk) disable iff (!rst_n)
    !irq_glob_en |-> !irq);

  assert_int_no_dav_irq_R7: assert property (@(posedge clk) disable iff (!rst_n)
    (ext_sel == 2'b00 && edge_pend == 2'b00) |-> !irq);

  assert_switch_clr_a_R9: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(ext_sel[0]) |-> !dav[0]);

  assert_switch_clr_b_R9: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(ext_sel[1]) |-> !dav[1]);

  assert_blank_hold_a_R9: assert property (@(posedge clk) disable iff (!rst_n)
    blank[0] |=> $stable(word_a));

  assert_blank_hold_b_R9: assert property (@(posedge clk) disable iff (!rst_n)
    blank[1] |=> $stable(word_b));

  assert_latch_sets_dav_a_R5: assert property (@(posedge clk) disable iff (!rst_n)
    !$stable(word_a) |-> dav[0]);

  assert_latch_sets_dav_b_R5: assert property (@(posedge clk) disable iff (!rst_n)
    !$stable(word_b) |-> dav[1]);
endmodule

bind bank_capture_ctrl bank_capture_ctrl_chk #(.DW(DW), .REG_W(REG_W)) u_chk (
  .clk         (clk),
  .rst_n       (rst_n),
  .irq_glob_en (irq_glob_en),
  .irq         (irq),
  .cmd_rdata   (cmd_rdata),
  .dav         (dav),
  .ext_sel     (ext_sel_v),
  .edge_pend   (edge_v),
  .blank       (blank_v),
  .word_a      (words[0]),
  .word_b      (words[1])
);

// File: tb/bank_capture_ctrl_tb.sv
module bank_capture_ctrl_tb;
  logic        clk = 1'b0;
  logic        rst_n, bank_sel, irq_glob_en, cmd_wr, data_rd;
  logic        strobe_a, strobe_b;
  logic [15:0] cmd_wdata, in_a, in_b;
  logic [15:0] cmd_rdata, data_rdata;
  logic [1:0]  dav;
  logic        irq;
  int          n_run = 0, n_fail = 0;
  logic [2:0]  exp_cmd [2];

  always #10 clk = ~clk;

  bank_capture_ctrl u_dut (
    .clk(clk), .rst_n(rst_n), .bank_sel(bank_sel), .irq_glob_en(irq_glob_en),
    .cmd_wr(cmd_wr), .cmd_wdata(cmd_wdata), .cmd_rdata(cmd_rdata),
    .data_rd(data_rd), .data_rdata(data_rdata), .in_a(in_a), .in_b(in_b),
    .strobe_a(strobe_a), .strobe_b(strobe_b), .dav(dav), .irq(irq)
  );

  task automatic step(int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic check(string req, logic [31:0] act, logic [31:0] exp);
    n_run++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic wr_cmd(logic b, logic [15:0] v);
    bank_sel = b; cmd_wdata = v; cmd_wr = 1'b1;
    step(1);
    cmd_wr = 1'b0;
  endtask

  task automatic rd_data(logic b);
    bank_sel = b; data_rd = 1'b1;
    step(1);
    data_rd = 1'b0;
  endtask

  task automatic pulse_b(logic [15:0] w);
    in_b = w; strobe_b = 1'b1;
    step(3);
    strobe_b = 1'b0;
    step(2);
  endtask

  initial begin
    repeat (20000) @(posedge clk);
    n_fail++;
    $display("FAIL watchdog actual=timeout expected=done");
    $display("  [TB] %0d tests run, %0d failed", n_run, n_fail);
    $finish;
  end

  initial begin
    rst_n = 1'b0; bank_sel = 1'b0; irq_glob_en = 1'b1; cmd_wr = 1'b0;
    data_rd = 1'b0; strobe_a = 1'b0; strobe_b = 1'b0;
    cmd_wdata = '0; in_a = '0; in_b = '0;
    step(3);
    rst_n = 1'b1;
    step(1);

    // R1 reset readback on both banks
    bank_sel = 1'b0; #1 check("R1 reset cmd A", cmd_rdata, 16'hFFF8);
    bank_sel = 1'b1; #1 check("R1 reset cmd B", cmd_rdata, 16'hFFF8);
    check("R5 reset dav", dav, 2'b00);
    check("R10 reset irq", irq, 1'b0);
    check("R8 reset capture", data_rdata, 16'h0000);

    // R1/R2 exhaustive command sweep over both banks
    exp_cmd[0] = 3'd0; exp_cmd[1] = 3'd0;
    for (int b = 0; b < 2; b++) begin
      for (int v = 0; v < 8; v++) begin
        wr_cmd(1'(b), {13'h1555 ^ 13'(v * 37), 3'(v)});
        exp_cmd[b] = 3'(v);
        bank_sel = 1'(b); #1 check("R1 readback", cmd_rdata, {13'h1FFF, exp_cmd[b]});
        bank_sel = 1'(1 - b); #1 check("R2 other bank", cmd_rdata, {13'h1FFF, exp_cmd[1 - b]});
      end
    end
    wr_cmd(1'b0, 16'h0004);   // A: internal clock, dav irq enable set
    wr_cmd(1'b1, 16'h0000);
    rd_data(1'b1);

    // R3 / R7 internal capture on A
    in_a = 16'h1234;
    step(60);
    check("R3 dav A", dav[0], 1'b1);
    bank_sel = 1'b0; #1 check("R3 data A", data_rdata, 16'h1234);
    check("R7 no dav irq internal", irq, 1'b0);

    // R9 switch B to external with dav irq; R4 latency
    wr_cmd(1'b1, 16'h0006);
    step(4);
    in_b = 16'hA5A5; strobe_b = 1'b1;
    step(2);
    check("R4 not yet", dav[1], 1'b0);
    step(1);
    check("R4 dav B", dav[1], 1'b1);
    bank_sel = 1'b1; #1 check("R4 data B", data_rdata, 16'hA5A5);
    check("R6 dav irq", irq, 1'b1);
    strobe_b = 1'b0;
    irq_glob_en = 1'b0; #1 check("R10 global off", irq, 1'b0);
    irq_glob_en = 1'b1; #1 check("R10 global on", irq, 1'b1);
    rd_data(1'b1);
    check("R5 read clears dav B", dav[1], 1'b0);
    check("R5 irq cleared", irq, 1'b0);
    check("R2 A untouched", dav[0], 1'b1);

    // R6 without dav enable: no irq; R8 edge irq
    wr_cmd(1'b1, 16'h0003);
    pulse_b(16'hA5A5);
    check("R8 same word dav", dav[1], 1'b1);
    check("R6 dav irq disabled", irq, 1'b0);
    rd_data(1'b1);
    pulse_b(16'h5A5A);
    check("R8 edge irq", irq, 1'b1);
    bank_sel = 1'b1; #1 check("R8 data", data_rdata, 16'h5A5A);
    rd_data(1'b1);
    check("R8 read clears edge", irq, 1'b0);

    // R9 A: strobe edge detected inside the blanking window is lost
    wr_cmd(1'b0, 16'h0000);
    step(60);
    check("R9 dav A before switch", dav[0], 1'b1);
    strobe_a = 1'b1;
    step(1);
    wr_cmd(1'b0, 16'h0002);
    check("R9 dav cleared", dav[0], 1'b0);
    step(5);
    check("R9 capture lost", dav[0], 1'b0);
    strobe_a = 1'b0; in_a = 16'h7777;
    step(2);
    strobe_a = 1'b1;
    step(3);
    check("R4 dav A ext", dav[0], 1'b1);
    bank_sel = 1'b0; #1 check("R4 data A ext", data_rdata, 16'h7777);
    strobe_a = 1'b0;
    step(2);

    $display("  [TB] %0d tests run, %0d failed", n_run, n_fail);
    $finish;
  end
endmodule